// File: doc/BRIEF.md
# Ring Run-Chain Synchronizer

This block decides, every clock cycle, whether each of three pulse-generator channels is running. The channels form a ring: every channel can either run from its own software run bit (a master) or inherit the run state of the channel before it (a slave). One master can therefore start or stop any number of slaves chained behind it in the same clock cycle. The waveform generators themselves sit outside the block and only consume the registered run outputs.

Faults arrive as single-cycle pulses, one per channel, each with an enable bit and a 3-bit mode code. A fault of the chaining mode (code 7) stops the whole chain group it belongs to, travelling forward and backward along the links. A fault of any other mode only clears the run bit of its own channel. A ring in which every channel is a slave has no master. The block reports this as a configuration error and holds every run output low.

Top module: `run_chain_sync`

## Requirements
- R1: A synchronous active-high reset clears all software run bits, all run outputs and the configuration-error flag.
- R2: A channel whose chain-select bit is 0 is a master. Its run output equals its own run bit. A set or clear pulse sampled at a clock edge shows on the run output right after that same edge.
- R3: A channel whose chain-select bit is 1 is a slave. Its run output equals the run output of channel (n+2) mod 3, in the same cycle, so a master and all slaves behind it, including across the wrap from channel 2 to channel 0, start together.
- R4: Clearing the run bit of a master stops every slave chained behind it in the same cycle.
- R5: A slave whose own run bit is set runs regardless of its predecessor: its output is its own bit OR its predecessor's output.
- R6: An enabled fault with mode code 7 (mode of channel n in fault_mode bits 3n+2..3n) clears the run bits of every channel in the same chain group, meaning the master and all channels linked to it, wherever in the group the fault arose. All of them stop after the next edge and stay stopped until software sets the bit again. Channels in other groups are unaffected.
- R7: An enabled fault with any mode other than 7 clears only its own channel's run bit. A slave with its own bit clear therefore keeps following its predecessor.
- R8: A fault pulse whose enable bit is 0 has no effect.
- R9: When all three chain-select bits are 1, the configuration-error flag is 1 and every run output is 0 after the next edge. The run bits are kept and take effect again once the configuration is legal.
- R10: A clear pulse, or a fault that clears a channel, overrides a set pulse on the same channel in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run_set | input | 3 | Per-channel pulse that sets the software run bit |
| run_clr | input | 3 | Per-channel pulse that clears the software run bit |
| chain_sel | input | 3 | Per-channel: 1 = take run from previous channel |
| fault_mode | input | 9 | Per-channel 3-bit fault mode, channel n at bits 3n+2..3n |
| fault_en | input | 3 | Per-channel fault enable |
| fault_pulse | input | 3 | Per-channel single-cycle fault event |
| run_out | output | 3 | Registered effective run per channel |
| cfg_err | output | 1 | Registered flag: every channel is a slave |

## Verification
The assertions assume that fault and run-control inputs are synchronous to the clock and change only between edges. They also assume that chain-select and fault-mode settings are quasi-static around the edge that samples them. The stimulus drives every input two nanoseconds after a rising edge, keeps pulses one cycle wide, and changes the chain configuration only while no set, clear or fault pulse is present. Every expected run pattern is worked out by hand from the ring topology of each scenario.

// File: rtl/run_chain_pkg.sv
package run_chain_pkg;
  localparam int unsigned MODE_W = 3;
  localparam logic [MODE_W-1:0] CHAIN_FAULT_MODE = 3'd7;

  function automatic int unsigned idx_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/run_bit_bank.sv
module run_bit_bank #(
  parameter int unsigned NUM_CH = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] set_i,
  input  logic [NUM_CH-1:0] clr_i,
  input  logic [NUM_CH-1:0] fclr_i,
  output logic [NUM_CH-1:0] bit_nxt,
  output logic [NUM_CH-1:0] bit_q
);
  always_comb begin
    if (rst) bit_nxt = '0;
    else     bit_nxt = (bit_q | set_i) & ~clr_i & ~fclr_i;
  end

  always_ff @(posedge clk) bit_q <= bit_nxt;

  generate
    for (genvar n = 0; n < NUM_CH; n++) begin : g_chk
      // R10: clear wins over set
      a_r10_clear_wins: assert property (@(posedge clk) disable iff (rst)
        (set_i[n] && clr_i[n]) |=> !bit_q[n]);
      // R6/R7: a fault-driven clear wins over set
      a_r10_fault_wins: assert property (@(posedge clk) disable iff (rst)
        (set_i[n] && fclr_i[n]) |=> !bit_q[n]);
    end
  endgenerate
endmodule

// File: rtl/ring_resolver.sv
module ring_resolver #(
  parameter int unsigned NUM_CH = 3,
  parameter int unsigned IW = 2
) (
  input  logic [NUM_CH-1:0]    sel_i,
  input  logic [NUM_CH-1:0]    run_i,
  output logic [NUM_CH-1:0]    eff_o,
  output logic [NUM_CH*IW-1:0] root_o,
  output logic                 has_master_o
);
  localparam logic [IW-1:0] LAST = IW'(NUM_CH - 1);

  function automatic logic [IW-1:0] prev_idx(input logic [IW-1:0] i);
    return (i == '0) ? LAST : i - 1'b1;
  endfunction

  assign has_master_o = ~&sel_i;

  // Group root: first master found walking backwards; depends on sel only.
  always_comb begin
    for (int n = 0; n < NUM_CH; n++) begin
      logic [IW-1:0] idx;
      logic [IW-1:0] rt;
      logic          found;
      idx   = IW'(n);
      rt    = IW'(n);
      found = 1'b0;
      for (int s = 0; s < NUM_CH; s++) begin
        if (!found) begin
          if (!sel_i[idx]) begin
            found = 1'b1;
            rt    = idx;
          end else begin
            idx = prev_idx(idx);
          end
        end
      end
      root_o[n*IW +: IW] = rt;
    end
  end

  // Effective run: OR of own bits along the chain back to its master.
  always_comb begin
    for (int n = 0; n < NUM_CH; n++) begin
      logic [IW-1:0] idx;
      logic          acc;
      logic          stop;
      idx  = IW'(n);
      acc  = 1'b0;
      stop = 1'b0;
      for (int s = 0; s < NUM_CH; s++) begin
        if (!stop) begin
          acc = acc | run_i[idx];
          if (!sel_i[idx]) stop = 1'b1;
          else             idx  = prev_idx(idx);
        end
      end
      eff_o[n] = acc & has_master_o;
    end
  end
endmodule

// File: rtl/fault_router.sv
module fault_router
  import run_chain_pkg::*;
#(
  parameter int unsigned NUM_CH = 3,
  parameter int unsigned IW = 2
) (
  input  logic [NUM_CH-1:0]        pulse_i,
  input  logic [NUM_CH-1:0]        en_i,
  input  logic [NUM_CH*MODE_W-1:0] mode_i,
  input  logic [NUM_CH*IW-1:0]     root_i,
  input  logic                     has_master_i,
  output logic [NUM_CH-1:0]        clr_o
);
  logic [NUM_CH-1:0] hit_chain;
  logic [NUM_CH-1:0] hit_local;

  generate
    for (genvar n = 0; n < NUM_CH; n++) begin : g_cls
      logic is_chain;
      assign is_chain     = (mode_i[n*MODE_W +: MODE_W] == CHAIN_FAULT_MODE);
      assign hit_chain[n] = pulse_i[n] & en_i[n] & is_chain;
      assign hit_local[n] = pulse_i[n] & en_i[n] & ~is_chain;
    end
  endgenerate

  always_comb begin
    clr_o = hit_local;
    for (int m = 0; m < NUM_CH; m++) begin
      for (int n = 0; n < NUM_CH; n++) begin
        if (hit_chain[n] && (!has_master_i || n == m ||
            root_i[n*IW +: IW] == root_i[m*IW +: IW]))
          clr_o[m] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/run_chain_sync.sv
module run_chain_sync
  import run_chain_pkg::*;
#(
  parameter int unsigned NUM_CH = 3
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NUM_CH-1:0]        run_set,
  input  logic [NUM_CH-1:0]        run_clr,
  input  logic [NUM_CH-1:0]        chain_sel,
  input  logic [NUM_CH*MODE_W-1:0] fault_mode,
  input  logic [NUM_CH-1:0]        fault_en,
  input  logic [NUM_CH-1:0]        fault_pulse,
  output logic [NUM_CH-1:0]        run_out,
  output logic                     cfg_err
);
  localparam int unsigned IW = idx_width(NUM_CH);

  logic [NUM_CH-1:0]    bit_nxt;
  logic [NUM_CH-1:0]    bit_q;
  logic [NUM_CH-1:0]    fault_clr;
  logic [NUM_CH-1:0]    eff;
  logic [NUM_CH*IW-1:0] root;
  logic                 has_master;

  run_bit_bank #(.NUM_CH(NUM_CH)) u_bank (
    .clk(clk), .rst(rst), .set_i(run_set), .clr_i(run_clr),
    .fclr_i(fault_clr), .bit_nxt(bit_nxt), .bit_q(bit_q)
  );

  ring_resolver #(.NUM_CH(NUM_CH), .IW(IW)) u_ring (
    .sel_i(chain_sel), .run_i(bit_nxt), .eff_o(eff),
    .root_o(root), .has_master_o(has_master)
  );

  fault_router #(.NUM_CH(NUM_CH), .IW(IW)) u_route (
    .pulse_i(fault_pulse), .en_i(fault_en), .mode_i(fault_mode),
    .root_i(root), .has_master_i(has_master), .clr_o(fault_clr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      run_out <= '0;
      cfg_err <= 1'b0;
    end else begin
      run_out <= eff;
      cfg_err <= ~has_master;
    end
  end

  // R9: a ring without master reports and holds everything stopped
  a_r9_no_master: assert property (@(posedge clk) disable iff (rst)
    (&chain_sel) |=> (cfg_err && run_out == '0));

  generate
    for (genvar n = 0; n < NUM_CH; n++) begin : g_chk
      localparam int unsigned P = (n + NUM_CH - 1) % NUM_CH;
      logic chain_hit;
      assign chain_hit = fault_pulse[n] & fault_en[n] &
                         (fault_mode[n*MODE_W +: MODE_W] == CHAIN_FAULT_MODE);
      // R2
      a_r2_master_own_bit: assert property (@(posedge clk) disable iff (rst)
        !chain_sel[n] |=> run_out[n] == bit_q[n]);
      // R3/R5
      a_r3_slave_follows: assert property (@(posedge clk) disable iff (rst)
        (chain_sel[n] && !(&chain_sel)) |=> run_out[n] == (run_out[P] | bit_q[n]));
      // R6
      a_r6_chain_fault_stops: assert property (@(posedge clk) disable iff (rst)
        chain_hit |=> !run_out[n] && !bit_q[n]);
    end
  endgenerate
endmodule

// File: tb/run_chain_sync_test.sv
`timescale 1ns/1ps
module run_chain_sync_test;
  logic       clk = 1'b0;
  logic       rst;
  logic [2:0] run_set, run_clr, chain_sel, fault_en, fault_pulse;
  logic [8:0] fault_mode;
  logic [2:0] run_out;
  logic       cfg_err;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  run_chain_sync uut (
    .clk(clk), .rst(rst), .run_set(run_set), .run_clr(run_clr),
    .chain_sel(chain_sel), .fault_mode(fault_mode), .fault_en(fault_en),
    .fault_pulse(fault_pulse), .run_out(run_out), .cfg_err(cfg_err)
  );

  task automatic cyc();
    @(posedge clk);
    #2;
  endtask

  task automatic chk(input string tag, input logic [2:0] act, input logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: run_out actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic chk_err(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: cfg_err actual %b expected %b", tag, act, exp);
    end
  endtask

  // one cycle of pulses, then pulses return to zero
  task automatic drive(input logic [2:0] s, input logic [2:0] c,
                       input logic [2:0] fp, input logic [2:0] fe,
                       input logic [8:0] fm);
    run_set = s; run_clr = c; fault_pulse = fp; fault_en = fe; fault_mode = fm;
    cyc();
    run_set = '0; run_clr = '0; fault_pulse = '0;
  endtask

  task automatic clear_all();
    drive(3'b000, 3'b111, 3'b000, 3'b000, 9'd0);
  endtask

  task automatic t_reset();
    rst = 1'b1; run_set = '0; run_clr = '0; chain_sel = '0;
    fault_en = '0; fault_pulse = '0; fault_mode = '0;
    cyc(); cyc();
    chk("R1 reset run_out", run_out, 3'b000);
    chk_err("R1 reset cfg_err", cfg_err, 1'b0);
    run_set = 3'b111; cyc();
    chk("R1 set ignored in reset", run_out, 3'b000);
    run_set = '0; rst = 1'b0; cyc();
    chk("R1 run bits cleared by reset", run_out, 3'b000);
  endtask

  task automatic t_master();
    chain_sel = 3'b000;
    drive(3'b010, 3'b000, 3'b000, 3'b000, 9'd0);
    chk("R2 master set ch1", run_out, 3'b010);
    drive(3'b000, 3'b010, 3'b000, 3'b000, 9'd0);
    chk("R2 master clear ch1", run_out, 3'b000);
  endtask

  task automatic t_chain();
    chain_sel = 3'b110; cyc();
    drive(3'b001, 3'b000, 3'b000, 3'b000, 9'd0);
    chk("R3 ch0 drives ch1 ch2", run_out, 3'b111);
    drive(3'b000, 3'b001, 3'b000, 3'b000, 9'd0);
    chk("R4 master stop stops slaves", run_out, 3'b000);
    chain_sel = 3'b011; cyc();
    drive(3'b100, 3'b000, 3'b000, 3'b000, 9'd0);
    chk("R3 wrap ch2 drives ch0 ch1", run_out, 3'b111);
    drive(3'b000, 3'b100, 3'b000, 3'b000, 9'd0);
    chk("R4 wrap stop", run_out, 3'b000);
  endtask

  task automatic t_slave_own();
    chain_sel = 3'b110; cyc();
    drive(3'b100, 3'b000, 3'b000, 3'b000, 9'd0);
    chk("R5 slave own bit", run_out, 3'b100);
    clear_all();
  endtask

  task automatic t_fault_chain();
    chain_sel = 3'b110; cyc();
    drive(3'b001, 3'b000, 3'b000, 3'b000, 9'd0);
    chk("R6 pre", run_out, 3'b111);
    drive(3'b000, 3'b000, 3'b100, 3'b100, 9'b111_000_000);
    chk("R6 slave fault stops chain", run_out, 3'b000);
    cyc();
    chk("R6 stays stopped", run_out, 3'b000);
    drive(3'b001, 3'b000, 3'b000, 3'b000, 9'd0);
    chk("R6 restart by software", run_out, 3'b111);
    drive(3'b000, 3'b000, 3'b001, 3'b001, 9'b000_000_111);
    chk("R6 master fault stops chain", run_out, 3'b000);
    // two groups: {ch0, ch1} and {ch2}
    chain_sel = 3'b010; cyc();
    drive(3'b101, 3'b000, 3'b000, 3'b000, 9'd0);
    chk("R6 two groups pre", run_out, 3'b111);
    drive(3'b000, 3'b000, 3'b010, 3'b010, 9'b000_111_000);
    chk("R6 other group unaffected", run_out, 3'b100);
    clear_all();
  endtask

  task automatic t_fault_local();
    chain_sel = 3'b000; cyc();
    drive(3'b111, 3'b000, 3'b000, 3'b000, 9'd0);
    drive(3'b000, 3'b000, 3'b010, 3'b010, 9'b000_011_000);
    chk("R7 local fault only ch1", run_out, 3'b101);
    clear_all();
    chain_sel = 3'b110; cyc();
    drive(3'b001, 3'b000, 3'b000, 3'b000, 9'd0);
    drive(3'b000, 3'b000, 3'b100, 3'b100, 9'b010_000_000);
    chk("R7 local fault on slave keeps chain", run_out, 3'b111);
    clear_all();
  endtask

  task automatic t_fault_disabled();
    chain_sel = 3'b000; cyc();
    drive(3'b111, 3'b000, 3'b000, 3'b000, 9'd0);
    drive(3'b000, 3'b000, 3'b001, 3'b000, 9'b000_000_111);
    chk("R8 disabled chain fault", run_out, 3'b111);
    drive(3'b000, 3'b000, 3'b010, 3'b000, 9'b000_001_000);
    chk("R8 disabled local fault", run_out, 3'b111);
    clear_all();
  endtask

  task automatic t_cfg();
    chain_sel = 3'b000; cyc();
    drive(3'b001, 3'b000, 3'b000, 3'b000, 9'd0);
    chk("R9 pre", run_out, 3'b001);
    chain_sel = 3'b111; cyc();
    chk("R9 no master stops all", run_out, 3'b000);
    chk_err("R9 flag raised", cfg_err, 1'b1);
    chain_sel = 3'b000; cyc();
    chk("R9 bit kept", run_out, 3'b001);
    chk_err("R9 flag cleared", cfg_err, 1'b0);
    clear_all();
  endtask

  task automatic t_prio();
    chain_sel = 3'b000; cyc();
    drive(3'b001, 3'b001, 3'b000, 3'b000, 9'd0);
    chk("R10 clear beats set", run_out, 3'b000);
    drive(3'b010, 3'b000, 3'b010, 3'b010, 9'b000_111_000);
    chk("R10 fault beats set", run_out, 3'b000);
  endtask

  initial begin
    t_reset();
    t_master();
    t_chain();
    t_slave_own();
    t_fault_chain();
    t_fault_local();
    t_fault_disabled();
    t_cfg();
    t_prio();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule